// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the controller side of a two-wire serial management bus to Ethernet PHY devices. A single request gives the direction, the PHY address, the register address and, for a write, the 16-bit value. The block turns it into one complete management frame. It derives the management clock from the system clock through a programmable divider. It shifts the frame out on the data line and controls an output-enable, so that a pad outside the block can tri-state the line. On a read it gives up the line at the turnaround, checks that the PHY answers with a zero, and collects the 16-bit register value.

At the end of the transaction a one-cycle `done` pulse presents the read value and an error flag. `busy` is high from the moment a request is taken until the cycle after the line has been released. Requests that arrive while `busy` is high are dropped.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 bits of value 1, driven with the output-enable high. Bit k of a frame is the line value at the k-th rising edge of MDC after the request.
- R2: Bits 32 and 33 are the start pattern: 0 then 1.
- R3: Bits 34 and 35 are the operation code: 1,0 for a read and 0,1 for a write.
- R4: Bits 36 to 40 carry the PHY address and bits 41 to 45 carry the register address, each most significant bit first.
- R5: On a write, bits 46 and 47 are driven as 1 then 0, and bits 48 to 63 carry the write data, most significant bit first. The output-enable stays high through bit 63.
- R6: After the last bit, the output-enable is low for one cycle while `busy` is still high. In the next cycle `busy` is low and `done` is high for exactly one cycle.
- R7: On a read, the output-enable is low from bit 46 through bit 63, so the line is released for the whole turnaround and data phase.
- R8: On a read whose bit 47 samples 0, `rd_data` holds bits 48 to 63 as sampled on MDC rising edges (first bit is bit 15), and `rd_err` is 0, both valid while `done` is high.
- R9: On a read whose bit 47 samples 1, `rd_err` is 1 and `rd_data` is 16'hFFFF while `done` is high.
- R10: `busy` rises in the cycle after a request is accepted. A `req_valid` seen while `busy` is high changes neither the frame in flight nor the number of `done` pulses, and it starts no later frame.
- R11: Each half period of MDC lasts `clk_div`+1 system clock cycles. MDC is low whenever `busy` is low.
- R12: While the output-enable stays high, the data output changes only in the cycle in which MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_div | input | DIV_W | MDC half period minus one, in system clocks |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_read | input | 1 | 1 selects a read, 0 a write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result (all ones on error) |
| rd_err | output | 1 | PHY did not drive the turnaround zero |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The case that is hardest to reach is a read in which the PHY fails to pull the second turnaround bit low. It can only be produced by a responder that follows the frame bit by bit. The bench therefore has a small PHY model that counts MDC rising edges, and changes its drive only after MDC falls. For one read it leaves the turnaround bit high while still returning data bits, so the bench can confirm that the error path forces all ones and does not forward the sampled data. A second request pulsed in the middle of a frame shows that requests arriving while busy are dropped.

// File: rtl/mdio_pkg.sv
// Package: shared frame geometry and sequencer state for the MDIO master.
// Assumes the fixed clause-22 layout: preamble, start, opcode, two 5-bit
// addresses, two turnaround bits and 16 data bits.
package mdio_pkg;

    localparam int PRE_LEN    = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int HDR_LEN    = 2 + 2 + 2 * ADDR_W;
    localparam int FRAME_BITS = PRE_LEN + HDR_LEN + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + HDR_LEN);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_LEN + HDR_LEN + 1);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + HDR_LEN + 2);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SHIFT  = 2'd1,
        SEQ_FINISH = 2'd2
    } seq_state_t;

endpackage

// File: rtl/mdio_clk_gen.sv
// Module: MDC divider. While enabled, toggles mdc every div+1 system clocks
// and flags the cycle before each rising and falling edge. When disabled,
// holds mdc low and preloads the counter so the first half period is full.
// Assumes div is stable while enabled.
module mdio_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt;
    logic             tick;

    // Tick when the half-period counter has expired.
    assign tick      = en && (cnt == '0);
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    // Count down the half period and toggle mdc on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= div;
            mdc <= 1'b0;
        end else if (cnt == '0) begin
            cnt <= div;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R11: a disabled divider parks mdc low
    AST_MDC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc); // R11

endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer. Loads the whole 64-bit frame on acceptance, shifts
// it out one bit per MDC falling tick, releases the line for the read
// turnaround, samples the PHY on MDC rising ticks and reports the result.
// Assumes rise_tick and fall_tick never coincide.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              clk_en,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              mdio_o,
    output logic              mdio_oe
);

    seq_state_t               state;
    logic [IDX_W-1:0]         idx;
    logic [FRAME_BITS-1:0]    tx_sr;
    logic [DATA_W-1:0]        rx_sr;
    logic                     is_read;
    logic                     ta_bad;
    logic [FRAME_BITS-1:0]    frame;

    // Assemble the outgoing frame from the request fields.
    always_comb begin
        frame = {{PRE_LEN{1'b1}}, 2'b01,
                 req_read ? 2'b10 : 2'b01,
                 req_phy, req_reg,
                 req_read ? 2'b11 : 2'b10,
                 req_read ? {DATA_W{1'b1}} : req_wdata};
    end

    assign clk_en = (state == SEQ_SHIFT);
    assign busy   = (state != SEQ_IDLE);
    assign mdio_o = tx_sr[FRAME_BITS-1];

    // Main sequencer: accept, shift, sample, release and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            idx     <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            is_read <= 1'b0;
            ta_bad  <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        state   <= SEQ_SHIFT;
                        idx     <= '0;
                        tx_sr   <= frame;
                        is_read <= req_read;
                        ta_bad  <= 1'b0;
                        mdio_oe <= 1'b1;
                    end
                end
                SEQ_SHIFT: begin
                    if (rise_tick && is_read) begin
                        if (idx == TA2_IDX) begin
                            ta_bad <= mdio_i;
                        end
                        if (idx >= DAT_IDX) begin
                            rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
                        end
                    end
                    if (fall_tick) begin
                        if (idx == LAST_IDX) begin
                            state   <= SEQ_FINISH;
                            mdio_oe <= 1'b0;
                        end else begin
                            idx   <= idx + 1'b1;
                            tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                            if (is_read && (idx + 1'b1 == TA_IDX)) begin
                                mdio_oe <= 1'b0;
                            end
                        end
                    end
                end
                SEQ_FINISH: begin
                    state <= SEQ_IDLE;
                    done  <= 1'b1;
                    if (is_read) begin
                        rd_data <= ta_bad ? {DATA_W{1'b1}} : rx_sr;
                        rd_err  <= ta_bad;
                    end else begin
                        rd_err  <= 1'b0;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mdio_oe && $past(!mdio_oe) && $past(busy))); // R6
    AST_READ_TA_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SHIFT && is_read && idx >= TA_IDX) |-> !mdio_oe); // R7
    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_err) |-> (rd_data == {DATA_W{1'b1}})); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy); // R10

endmodule

// File: rtl/mdio_master.sv
// Module: MDIO management master top. Joins the MDC divider to the frame
// sequencer. Assumes an external pad combines mdio_o/mdio_oe/mdio_i and that
// the line is pulled high when nobody drives it.
module mdio_master #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [4:0]       req_phy,
    input  logic [4:0]       req_reg,
    input  logic [15:0]      req_wdata,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rd_data,
    output logic             rd_err,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    logic clk_en;
    logic rise_tick;
    logic fall_tick;

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .div       (clk_div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .clk_en    (clk_en),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .rd_err    (rd_err),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R11
    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc)); // R12

endmodule

// File: tb/tb_mdio_master.sv
// Directed bench with a bit-level PHY responder model.
module tb_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = 8'd1;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, rd_err, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // PHY model controls
    logic        phy_rd = 1'b0;
    logic        phy_ta = 1'b0;
    logic [15:0] phy_data = '0;

    // Monitor state
    int          rise_cnt = 0;
    int          done_cnt = 0;
    int          r12_viol = 0;
    logic        cap_o [64];
    logic        cap_oe[64];
    int          rise_at[64];
    logic        mdc_prev = 1'b0;
    logic        o_prev = 1'b0;
    logic        oe_prev = 1'b0;

    mdio_master #(.DIV_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
        .req_valid(req_valid), .req_read(req_read), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #5 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc = cyc + 1;
    end

    // Monitor and PHY responder, sampled between clock edges.
    initial forever begin
        @(negedge clk);
        if (done) done_cnt = done_cnt + 1;
        if (mdc && !mdc_prev) begin
            if (rise_cnt < 64) begin
                cap_o[rise_cnt]   = mdio_o;
                cap_oe[rise_cnt]  = mdio_oe;
                rise_at[rise_cnt] = cyc;
            end
            rise_cnt = rise_cnt + 1;
        end
        if (!mdc && mdc_prev) begin
            if (phy_rd && rise_cnt == 47) mdio_i = phy_ta;
            else if (phy_rd && rise_cnt >= 48 && rise_cnt <= 63) mdio_i = phy_data[63 - rise_cnt];
            else mdio_i = 1'b1;
        end
        if (mdio_oe && oe_prev && (mdio_o != o_prev) && !(!mdc && mdc_prev))
            r12_viol = r12_viol + 1;
        mdc_prev = mdc;
        o_prev   = mdio_o;
        oe_prev  = mdio_oe;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        wait (cyc >= 150000);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
    end

    // Issue one request and wait for its done pulse; checks R6 and R10 timing.
    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input bit inject);
        bit   prev_busy, prev_oe, seen;
        int   n;
        int   d0;
        rise_cnt = 0;
        phy_rd   = rd;
        d0       = done_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        prev_busy = busy; prev_oe = mdio_oe; seen = 1'b0; n = 0;
        while (!seen && n < 20000) begin
            @(negedge clk);
            n = n + 1;
            if (inject && n == 30) begin
                req_valid = 1'b1; req_read = ~rd; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
            end
            if (inject && n == 31) req_valid = 1'b0;
            if (done) begin
                seen = 1'b1;
                chk(!busy && prev_busy && !prev_oe, "R6 release then busy drop",
                    {busy, prev_busy, prev_oe}, 3'b010);
            end else begin
                prev_busy = busy; prev_oe = mdio_oe;
            end
        end
        chk(seen, "R6 done seen", seen, 1);
        @(negedge clk);
        chk(!done, "R6 done one cycle", done, 0);
        chk(rise_cnt == 64, "R1 64 MDC rises per frame", rise_cnt, 64);
    endtask

    // Compare captured header bits 0..45 against the expected frame.
    task automatic check_header(input bit rd, input logic [4:0] phy, input logic [4:0] rg);
        logic [45:0] exp, got;
        logic [45:0] oe_got;
        exp = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg};
        for (int k = 0; k < 46; k++) begin
            got[45 - k]    = cap_o[k];
            oe_got[45 - k] = cap_oe[k];
        end
        chk(got[45:14] == 32'hFFFF_FFFF, "R1 preamble", got[45:14], 32'hFFFF_FFFF);
        chk(got[13:12] == 2'b01, "R2 start", got[13:12], 2'b01);
        chk(got[11:10] == exp[11:10], "R3 opcode", got[11:10], exp[11:10]);
        chk(got[9:0] == exp[9:0], "R4 addresses", got[9:0], exp[9:0]);
        chk(&oe_got, "R1 driven header", oe_got, {46{1'b1}});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mdc && !mdio_oe, "R11 reset idle",
            {busy, done, mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!mdc && !busy, "R11 mdc low idle", {mdc, busy}, 0);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
        logic [17:0] got;
        bit all_oe;
        run_frame(1'b0, phy, rg, wd, 1'b0);
        check_header(1'b0, phy, rg);
        all_oe = 1'b1;
        for (int k = 46; k < 64; k++) begin
            got[63 - k] = cap_o[k];
            if (!cap_oe[k]) all_oe = 1'b0;
        end
        chk(got == {2'b10, wd}, "R5 write ta+data", got, {2'b10, wd});
        chk(all_oe, "R5 write drives to end", all_oe, 1);
        chk(!mdio_oe, "R6 line released after write", mdio_oe, 0);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] pd, input bit bad_ta);
        bit any_oe;
        phy_data = pd;
        phy_ta   = bad_ta;
        run_frame(1'b1, phy, rg, 16'h0, 1'b0);
        check_header(1'b1, phy, rg);
        any_oe = 1'b0;
        for (int k = 46; k < 64; k++) if (cap_oe[k]) any_oe = 1'b1;
        chk(!any_oe, "R7 released turnaround+data", any_oe, 0);
        // result registers are held after done, sample now
        if (!bad_ta) begin
            chk(rd_data == pd, "R8 read data", rd_data, pd);
            chk(!rd_err, "R8 no error", rd_err, 0);
        end else begin
            chk(rd_data == 16'hFFFF, "R9 error data all ones", rd_data, 16'hFFFF);
            chk(rd_err, "R9 error flag", rd_err, 1);
        end
        phy_ta = 1'b0;
    endtask

    task automatic t_busy_ignore();
        int d0;
        logic [17:0] got;
        d0 = done_cnt;
        run_frame(1'b0, 5'h0A, 5'h11, 16'h5AA5, 1'b1);
        check_header(1'b0, 5'h0A, 5'h11);
        for (int k = 46; k < 64; k++) got[63 - k] = cap_o[k];
        chk(got == {2'b10, 16'h5AA5}, "R10 frame unchanged by request", got, {2'b10, 16'h5AA5});
        repeat (20) @(negedge clk);
        chk(done_cnt == d0 + 1, "R10 single done", done_cnt - d0, 1);
        chk(!busy, "R10 no queued frame", busy, 0);
    endtask

    task automatic t_divider(input logic [7:0] dv);
        clk_div = dv;
        run_frame(1'b0, 5'h03, 5'h04, 16'h0F0F, 1'b0);
        chk(rise_at[1] - rise_at[0] == 2 * (dv + 1), "R11 MDC period",
            rise_at[1] - rise_at[0], 2 * (dv + 1));
        chk(rise_at[63] - rise_at[62] == 2 * (dv + 1), "R11 MDC period late",
            rise_at[63] - rise_at[62], 2 * (dv + 1));
        clk_div = 8'd1;
    endtask

    initial begin
        t_reset();
        t_write(5'h01, 5'h00, 16'h8001);
        t_write(5'h1F, 5'h15, 16'hC3A7);
        t_read(5'h12, 5'h01, 16'hB00C, 1'b0);
        t_read(5'h05, 5'h1E, 16'h0001, 1'b0);
        t_read(5'h07, 5'h02, 16'h1234, 1'b1);
        t_busy_ignore();
        t_divider(8'd3);
        t_divider(8'd0);
        chk(r12_viol == 0, "R12 output changes only on MDC fall", r12_viol, 0);
        finish_run();
    end

endmodule